// File: doc/BRIEF.md
# Capacitive Channel Baseline and Retune Monitor

This block makes the per-channel decisions for a capacitive sensing front end. A scan sequencer presents one channel's conversion count at a time on a valid/ready input. For each accepted count, the block does three things. It compares the count with that channel's long-term baseline to raise proximity (channel 0) or touch (channels 1 and up). It checks whether the count has drifted out of the tuning band around the channel's target. It decides whether the analog front end must be retuned.

The retune search itself lives elsewhere and is driven through a start-pulse/done handshake. While a retune is in progress the block holds its input ready low, so the sequencer must keep its count stalled. A sample is taken only on a cycle where valid and ready are both high. The sequencer may hold valid high across stalled cycles without any side effect. Control inputs (reseed, redo request, band select, sensing mode) and the status outputs are plain levels or pulses.

Top module: `cap_chan_monitor`

## Requirements
- R1: The effective target is the 8-bit target register times 8, capped at TGT_MAX (4096). Channel 0 uses `prox_tgt`; every other channel uses `touch_tgt`.
- R2: A sample is out of band when its count is strictly below target−band or strictly above target+band. The band is target/8, or target/4 when `band_wide`=1. An out-of-band sample starts a retune: `retune_req` pulses high for exactly one cycle, and the sample changes no baseline.
- R3: A pulse on `redo_req` sets `redo_pending`. The retune starts on the following cycle, and `redo_pending` clears in the same cycle that `retune_req` rises.
- R4: Starting a retune clears every bit of `hit_map` and marks every channel for reseed on its next evaluation.
- R5: `retune_busy` rises together with `retune_req` and stays high until `retune_done`. `smp_ready` is low while busy or while a redo is pending. At `retune_done`, `tune_err` takes the inverse of `retune_ok` and holds that value until the next done.
- R6: A channel marked for reseed loads its baseline with count+8 in projected mode (`proj_mode`=1) or count−8 in self mode, saturating at the count range limits, and reports no hit. Reset and a `reseed_req` pulse mark all channels; `reseed_req` also clears all of `hit_map`.
- R7: The deviation is baseline−count in projected mode and count−baseline in self mode; a negative deviation counts as zero. Channel 0 hits when the deviation exceeds `prox_thr`. Channel n≥1 hits when the deviation exceeds (`touch_thr`/256)×baseline. The hit bit for channel c is `hit_map[c]`.
- R8: `prox_flag` is high whenever any bit of `hit_map` is high, so any touch forces proximity.
- R9: On an in-band, non-reseed evaluation with no hit, the baseline moves one count toward the sample. When the evaluation hits, the baseline stays frozen.
- R10: `out_valid` pulses for one cycle on the clock edge after an accepted sample, carrying that sample's channel in `out_chan` and the channel's resulting baseline in `out_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample offered by the scan sequencer |
| smp_ready | output | 1 | Block can accept a sample |
| smp_chan | input | CHW | Channel index of the sample |
| smp_count | input | CW | Conversion count of the sample |
| proj_mode | input | 1 | 1 = projected sensing, 0 = self sensing |
| band_wide | input | 1 | 1 = band is target/4, 0 = target/8 |
| reseed_req | input | 1 | Pulse: reseed all channels and clear hits |
| redo_req | input | 1 | Pulse: request a retune |
| prox_tgt | input | RW | Target register for channel 0 |
| touch_tgt | input | RW | Target register for channels 1 and up |
| prox_thr | input | RW | Proximity threshold in counts |
| touch_thr | input | RW | Touch threshold as a fraction of baseline in 1/256 units |
| retune_req | output | 1 | One-cycle retune start pulse |
| retune_done | input | 1 | Retune finished |
| retune_ok | input | 1 | Target reached, sampled at done |
| retune_busy | output | 1 | Retune in progress |
| tune_err | output | 1 | Last retune missed its target |
| redo_pending | output | 1 | Redo request not yet started |
| hit_map | output | NUM_CH | Per-channel proximity/touch status |
| prox_flag | output | 1 | Proximity, forced by any touch |
| out_valid | output | 1 | Evaluation result strobe |
| out_chan | output | CHW | Channel of the result |
| out_base | output | CW | Baseline of that channel after evaluation |

## Verification
The bench targets the exact band edges. A count equal to target±band must stay quiet, and one count beyond must start a retune. A design that used an inclusive comparison, or the wrong target register for channel 0, would retune on a legal count or miss an illegal one. The bench also checks that the reseed offset has the right sign for each sensing mode and saturates at zero. A wrong sign would hand a freshly seeded channel a false hit. Finally, it confirms that a hit freezes tracking and that both a retune and a reseed wipe every hit bit. A design that forgot either would leave stale touch status alive after recalibration.

// File: rtl/cap_mon_pkg.sv
package cap_mon_pkg;
  // Offset applied to the baseline when a channel is reseeded.
  localparam int SEED_OFS = 8;
  // Target register resolution: one register step is 8 counts.
  localparam int TGT_SHIFT = 3;
  typedef enum logic {SENSE_SELF = 1'b0, SENSE_PROJ = 1'b1} sense_e;
endpackage

// File: rtl/cap_band_chk.sv
module cap_band_chk #(
  parameter int CW = 16,
  parameter int RW = 8,
  parameter int TGT_MAX = 4096
) (
  input  logic [RW-1:0] tgt_reg,
  input  logic          wide,
  input  logic [CW-1:0] count,
  output logic          oob
);
  import cap_mon_pkg::*;
  localparam int EW = CW + 2;
  logic [EW-1:0] raw, tgt, band, lo, hi;

  always_comb begin
    raw  = EW'(tgt_reg) << TGT_SHIFT;
    tgt  = (raw > EW'(TGT_MAX)) ? EW'(TGT_MAX) : raw;
    band = wide ? (tgt >> 2) : (tgt >> 3);
    lo   = tgt - band;
    hi   = tgt + band;
    oob  = (EW'(count) < lo) || (EW'(count) > hi);
  end
endmodule

// File: rtl/cap_hit_eval.sv
module cap_hit_eval #(
  parameter int CW = 16,
  parameter int RW = 8
) (
  input  logic [CW-1:0] base,
  input  logic [CW-1:0] count,
  input  logic          proj,
  input  logic          is_prox,
  input  logic          seed,
  input  logic [RW-1:0] prox_thr,
  input  logic [RW-1:0] touch_thr,
  output logic          hit,
  output logic [CW-1:0] base_next
);
  import cap_mon_pkg::*;
  localparam int PW = CW + RW;
  logic [CW-1:0] dev, seeded;
  logic [CW:0]   up;
  logic [PW-1:0] lhs, rhs;

  always_comb begin
    // deviation in the direction a finger moves the count
    if (proj == SENSE_PROJ) dev = (base > count) ? base - count : '0;
    else                    dev = (count > base) ? count - base : '0;
    // compare dev > thr scaled by 2^RW to keep the fraction exact
    lhs = {dev, {RW{1'b0}}};
    rhs = is_prox ? PW'({prox_thr, {RW{1'b0}}})
                  : PW'(touch_thr) * PW'(base);
    up  = {1'b0, count} + (CW+1)'(SEED_OFS);
    if (proj == SENSE_PROJ) seeded = up[CW] ? '1 : up[CW-1:0];
    else                    seeded = (count < CW'(SEED_OFS)) ? '0 : count - CW'(SEED_OFS);

    if (seed) begin
      hit       = 1'b0;
      base_next = seeded;
    end else begin
      hit = lhs > rhs;
      if (hit)                base_next = base;
      else if (base < count)  base_next = base + 1'b1;
      else if (base > count)  base_next = base - 1'b1;
      else                    base_next = base;
    end
  end
endmodule

// File: rtl/cap_retune_ctl.sv
module cap_retune_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic redo_set,
  input  logic auto_trig,
  input  logic done,
  input  logic ok,
  output logic start,
  output logic req,
  output logic busy,
  output logic redo_pend,
  output logic err
);
  assign start = !busy && (redo_pend || auto_trig);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req <= 1'b0; busy <= 1'b0; redo_pend <= 1'b0; err <= 1'b0;
    end else begin
      req <= start;
      redo_pend <= start ? 1'b0 : (redo_pend | redo_set);
      if (start) busy <= 1'b1;
      else if (busy && done) begin
        busy <= 1'b0;
        err  <= !ok;
      end
    end
  end

  p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  p_req_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> busy);
  p_redo_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> !redo_pend);
  p_err_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> ($past(busy) && !busy));
endmodule

// File: rtl/cap_chan_monitor.sv
module cap_chan_monitor #(
  parameter int NUM_CH = 10,
  parameter int CW = 16,
  parameter int RW = 8,
  parameter int TGT_MAX = 4096,
  localparam int CHW = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [CHW-1:0]    smp_chan,
  input  logic [CW-1:0]     smp_count,
  input  logic              proj_mode,
  input  logic              band_wide,
  input  logic              reseed_req,
  input  logic              redo_req,
  input  logic [RW-1:0]     prox_tgt,
  input  logic [RW-1:0]     touch_tgt,
  input  logic [RW-1:0]     prox_thr,
  input  logic [RW-1:0]     touch_thr,
  output logic              retune_req,
  input  logic              retune_done,
  input  logic              retune_ok,
  output logic              retune_busy,
  output logic              tune_err,
  output logic              redo_pending,
  output logic [NUM_CH-1:0] hit_map,
  output logic              prox_flag,
  output logic              out_valid,
  output logic [CHW-1:0]    out_chan,
  output logic [CW-1:0]     out_base
);
  logic [CW-1:0]     base_q [NUM_CH];
  logic [NUM_CH-1:0] seed_q, hit_q;
  logic              accept, is_prox, oob, hit_n, start;
  logic [RW-1:0]     tgt_sel;
  logic [CW-1:0]     base_cur, base_n;

  assign accept   = smp_valid && smp_ready;
  assign is_prox  = (smp_chan == '0);
  assign tgt_sel  = is_prox ? prox_tgt : touch_tgt;
  assign base_cur = base_q[smp_chan];

  cap_band_chk #(.CW(CW), .RW(RW), .TGT_MAX(TGT_MAX)) u_band (
    .tgt_reg(tgt_sel), .wide(band_wide), .count(smp_count), .oob(oob));

  cap_hit_eval #(.CW(CW), .RW(RW)) u_eval (
    .base(base_cur), .count(smp_count), .proj(proj_mode), .is_prox(is_prox),
    .seed(seed_q[smp_chan]), .prox_thr(prox_thr), .touch_thr(touch_thr),
    .hit(hit_n), .base_next(base_n));

  cap_retune_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .redo_set(redo_req), .auto_trig(accept && oob),
    .done(retune_done), .ok(retune_ok), .start(start), .req(retune_req),
    .busy(retune_busy), .redo_pend(redo_pending), .err(tune_err));

  assign smp_ready = !retune_busy && !redo_pending;
  assign hit_map   = hit_q;
  // channel 0 proximity or any touch bit raises proximity
  assign prox_flag = |hit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) base_q[i] <= '0;
      seed_q <= '1; hit_q <= '0;
      out_valid <= 1'b0; out_chan <= '0; out_base <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_chan <= smp_chan;
        if (oob) out_base <= base_cur;
        else begin
          base_q[smp_chan] <= base_n;
          hit_q[smp_chan]  <= hit_n;
          seed_q[smp_chan] <= 1'b0;
          out_base         <= base_n;
        end
      end
      if (reseed_req) begin seed_q <= '1; hit_q <= '0; end
      if (start)      begin seed_q <= '1; hit_q <= '0; end
    end
  end

  p_clear_on_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retune_busy) |-> (hit_map == '0));
  p_outv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(smp_valid && smp_ready));
  p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    retune_busy |=> (!out_valid || $past(!retune_busy)));
endmodule

// File: tb/tb_cap_chan_monitor.sv
`timescale 1ns/1ps
module tb_cap_chan_monitor;
  localparam int NUM_CH = 10, CW = 16, RW = 8;
  localparam int CHW = $clog2(NUM_CH);

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, smp_ready;
  logic [CHW-1:0] smp_chan = '0;
  logic [CW-1:0] smp_count = '0;
  logic proj_mode = 1, band_wide = 0, reseed_req = 0, redo_req = 0;
  logic [RW-1:0] prox_tgt = 128, touch_tgt = 64, prox_thr = 4, touch_thr = 16;
  logic retune_req, retune_done = 0, retune_ok = 0, retune_busy, tune_err, redo_pending;
  logic [NUM_CH-1:0] hit_map;
  logic prox_flag, out_valid;
  logic [CHW-1:0] out_chan;
  logic [CW-1:0] out_base;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  cap_chan_monitor dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input int ch, input int cnt);
    @(negedge clk);
    smp_chan = CHW'(ch); smp_count = CW'(cnt); smp_valid = 1;
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic pulse_done(input bit ok);
    @(negedge clk); retune_done = 1; retune_ok = ok;
    @(negedge clk); retune_done = 0;
  endtask

  // vectors: channel, count, expected baseline, expected hit, expected prox
  localparam int NV = 9;
  localparam int V_CH  [NV] = '{1, 1, 1, 1, 0, 0, 0, 2, 2};
  localparam int V_CNT [NV] = '{512, 512, 470, 500, 1024, 1020, 1032, 576, 448};
  localparam int V_BASE[NV] = '{520, 519, 519, 518, 1032, 1032, 1032, 584, 584};
  localparam int V_HIT [NV] = '{0, 0, 1, 0, 0, 1, 0, 0, 1};
  localparam int V_PRX [NV] = '{0, 0, 1, 0, 0, 1, 0, 0, 1};

  initial begin
    #4_000_000;
    fails++; tests++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state (R5, R10)
    chk(!retune_busy && !retune_req && !tune_err && !redo_pending, "R5 reset idle", retune_busy, 0);
    chk(hit_map == 0 && !prox_flag && !out_valid && smp_ready, "R10 reset outputs", hit_map, 0);

    // table walk: R1 R6 R7 R8 R9 R10 in projected mode
    for (int i = 0; i < NV; i++) begin
      send(V_CH[i], V_CNT[i]);
      chk(out_valid && out_chan == CHW'(V_CH[i]) && !retune_req, "R10 result strobe", out_chan, V_CH[i]);
      chk(out_base == CW'(V_BASE[i]), "R9 R6 baseline", out_base, V_BASE[i]);
      chk(hit_map[V_CH[i]] == V_HIT[i][0], "R7 hit", hit_map[V_CH[i]], V_HIT[i]);
      chk(prox_flag == V_PRX[i][0], "R8 prox flag", prox_flag, V_PRX[i]);
    end

    // R2/R4: one count below the lower edge (448) starts a retune
    send(2, 447);
    chk(retune_req && retune_busy, "R2 retune start", retune_req, 1);
    chk(hit_map == 0, "R4 hits cleared", hit_map, 0);
    chk(!smp_ready, "R5 ready low while busy", smp_ready, 0);
    @(negedge clk);
    chk(!retune_req && retune_busy, "R2 req single pulse", retune_req, 0);
    pulse_done(0);
    chk(!retune_busy && tune_err, "R5 error on missed target", tune_err, 1);

    // R2 wide band, R6 reseed after retune
    band_wide = 1;
    send(1, 600);
    chk(!retune_req && out_base == 608, "R2 wide band keeps 600", out_base, 608);
    @(negedge clk);
    chk(!out_valid, "R10 strobe one cycle", out_valid, 0);
    band_wide = 0;

    // R1: register 255 -> target 2040, band 255, upper edge 2295
    touch_tgt = 255;
    send(3, 2295);
    chk(!retune_req && out_base == 2303, "R1 upper edge in band", out_base, 2303);
    send(3, 2296);
    chk(retune_req, "R1 one past edge retunes", retune_req, 1);
    pulse_done(1);
    chk(!retune_busy && !tune_err, "R5 error clears on success", tune_err, 0);
    touch_tgt = 64;

    // R3 redo request
    @(negedge clk); redo_req = 1;
    @(negedge clk); redo_req = 0;
    chk(redo_pending && !retune_req && !smp_ready, "R3 redo pending", redo_pending, 1);
    @(negedge clk);
    chk(retune_req && retune_busy && !redo_pending, "R3 redo started and cleared", redo_pending, 0);
    pulse_done(1);

    // R6/R7 self mode
    proj_mode = 0;
    send(1, 500);
    chk(out_base == 492 && !hit_map[1], "R6 self reseed minus 8", out_base, 492);
    send(1, 540);
    chk(hit_map[1] && out_base == 492, "R7 self touch, R9 frozen", out_base, 492);
    @(negedge clk); reseed_req = 1;
    @(negedge clk); reseed_req = 0;
    chk(hit_map == 0 && !prox_flag, "R6 reseed clears hits", hit_map, 0);
    send(1, 540);
    chk(out_base == 532 && !hit_map[1], "R6 reseed after pulse", out_base, 532);

    // R6 saturation at zero with target 0
    prox_tgt = 0;
    send(0, 0);
    chk(!retune_req && out_base == 0, "R6 self reseed saturates", out_base, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule